// File: doc/BRIEF.md
# Banked SRAM Bridge for a Multiplexed 8-bit CPU Bus

This block sits between the external memory bus of an 8-bit microcontroller and an asynchronous 512K x 8 static RAM, with an optional second chip of the same size. The CPU bus carries the low address byte and the data byte on the same eight wires. The high address byte has wires of its own. While the address strobe is high, the bridge captures the low byte and the high byte. Once the strobe has fallen, it treats the shared wires as data.

The 16-bit CPU address is decoded in two steps. Accesses below 0x2200 are served by the CPU's own on-chip memory, so the bridge leaves every SRAM chip enable inactive for them. The bridge then builds a 19-bit SRAM address from the CPU address and a set of bank-select inputs, which general-purpose pins normally drive. Two mapping styles are available. The window style stacks eight 56,832-byte windows (0x2200..0xFFFF) end to end in one chip, and a fourth bank bit picks the chip. The page style ignores CPU A15 and uses four bank bits as SRAM A18:A15, which gives sixteen 32 KB pages. In the page style, a split option can instead let CPU A15 choose between the two chips.

All outputs are registered on the system clock. The bank-select inputs are captured together with the address, so a change made during the data phase cannot corrupt the access in progress.

Top module: `banked_sram_bridge`

## Requirements
- R1: While `ale` is 1 at a clock edge, the bridge captures {`addr_hi`,`ad_in`} as the CPU address. While `ale` is 0, that address holds, so data bytes placed on `ad_in` during the data phase do not change `sram_addr`.
- R2: For a captured CPU address below 0x2200, both `sram_ce0_n` and `sram_ce1_n` stay 1, and so do `sram_oe_n` and `sram_we_n`.
- R3: When `cfg_mode` is 0 (window style), `sram_addr` equals `bank_sel[2:0]` * 56832 + (CPU address - 0x2200). For example, bank 0 at 0x2200 gives 0, and bank 7 at 0xFFFF gives 454655.
- R4: In the window style, `bank_sel[3]` selects the chip: 0 asserts `sram_ce0_n` (driven low) and 1 asserts `sram_ce1_n`. A mapped address above 0x7FFFF asserts no chip enable.
- R5: When `cfg_mode` is 1 (page style) and `cfg_split` is 0, `sram_addr` = {`bank_sel[3:0]`, CPU A14:A0}. CPU A15 is ignored, so 0xA200..0xFFFF alias 0x2200..0x7FFF, and only `sram_ce0_n` is ever asserted.
- R6: In the page style with `cfg_split` = 1, the address is formed as in R5. CPU A15 = 0 asserts `sram_ce0_n`, and CPU A15 = 1 asserts `sram_ce1_n`.
- R7: A decoded access occurs only while `ale` is 0. `sram_oe_n` goes low for `rd_n` = 0, and `sram_we_n` goes low for `wr_n` = 0 with `rd_n` = 1. When both strobes are low, the access is a read. No enable is ever active with both strobes high.
- R8: During a decoded read, `ad_oe` = 1, and `ad_out` carries the byte present on `sram_d_in` at the previous clock edge. During a decoded write, `sram_d_oe` = 1 and `sram_d_out` carries `ad_in`. Neither output-enable is 1 at any other time.
- R9: The bank-select inputs and the mapping configuration count only as sampled while `ale` is 1. Changes to `bank_sel` during the data phase leave `sram_addr` and the chip choice unchanged.
- R10: Every SRAM-side output and every bus-side output is registered, and changes one clock edge after the inputs that cause it are sampled.
- R11: While `rst_n` is 0, all active-low enables are 1, `ad_oe` and `sram_d_oe` are 0, and `sram_addr` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ale | input | 1 | Address strobe, 1 during the address phase |
| rd_n | input | 1 | CPU read strobe, active low |
| wr_n | input | 1 | CPU write strobe, active low |
| addr_hi | input | 8 | CPU address bits 15:8 |
| ad_in | input | 8 | Shared low-address / data byte from the CPU |
| ad_out | output | 8 | Read data returned to the CPU |
| ad_oe | output | 1 | 1 when the bridge drives the shared byte |
| bank_sel | input | 4 | Bank-select bits from general-purpose pins |
| cfg_mode | input | 1 | 0 = window style, 1 = 32 KB page style |
| cfg_split | input | 1 | Page style: CPU A15 selects the chip |
| sram_addr | output | 19 | SRAM address |
| sram_ce0_n | output | 1 | First chip enable, active low |
| sram_ce1_n | output | 1 | Second chip enable, active low |
| sram_oe_n | output | 1 | SRAM output enable, active low |
| sram_we_n | output | 1 | SRAM write enable, active low |
| sram_d_in | input | 8 | Data read from the SRAM |
| sram_d_out | output | 8 | Data written to the SRAM |
| sram_d_oe | output | 1 | 1 when the bridge drives the SRAM data bus |

## Verification
The assertions check the following on every cycle:
- The captured address cannot move while the strobe is low.
- No chip enable follows a captured address inside the on-chip hole.
- At most one chip is selected at a time.
- Output and write enables are never low together, and each always comes with the matching data-direction enable.
- The second chip is enabled only in a configuration that allows it.

Only the bench's scenarios can show the arithmetic of the two mappings, the alias of the upper page window, the chip choice by A15 and by the fourth bank bit, the read priority when both strobes are low, and the fact that bank changes during the data phase have no effect. The bench shows these by comparing addresses and data against an independent model, across directed edge addresses and a seeded random mix.

// File: rtl/sbr_pkg.sv
package sbr_pkg;

    // Mapping style selected by the configuration input
    typedef enum logic {
        MAP_WINDOW = 1'b0,
        MAP_PAGE32 = 1'b1
    } map_mode_e;

    localparam int unsigned CPU_AW_DEF  = 16;
    localparam int unsigned DATA_W_DEF  = 8;
    localparam int unsigned SRAM_AW_DEF = 19;
    localparam int unsigned BANK_W_DEF  = 4;
    localparam int unsigned WBANK_W_DEF = 3;
    localparam int unsigned NCHIP       = 2;

endpackage

// File: rtl/sbr_addr_latch.sv
module sbr_addr_latch #(
    parameter int unsigned CPU_AW = 16,
    parameter int unsigned DATA_W = 8,
    parameter int unsigned BANK_W = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     ale,
    input  logic [CPU_AW-DATA_W-1:0] addr_hi,
    input  logic [DATA_W-1:0]        ad_in,
    input  logic [BANK_W-1:0]        bank_sel,
    input  logic                     cfg_mode,
    input  logic                     cfg_split,
    output logic [CPU_AW-1:0]        lat_addr,
    output logic [BANK_W-1:0]        lat_bank,
    output logic                     lat_mode,
    output logic                     lat_split
);

    typedef struct packed {
        logic [CPU_AW-1:0] addr;
        logic [BANK_W-1:0] bank;
        logic              mode;
        logic              split;
    } lat_t;

    lat_t lat_d, lat_q;

    // Follows the bus while the strobe is high, holds once it has fallen
    always_comb begin
        lat_d = lat_q;
        if (ale) begin
            lat_d.addr  = {addr_hi, ad_in};
            lat_d.bank  = bank_sel;
            lat_d.mode  = cfg_mode;
            lat_d.split = cfg_split;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) lat_q <= '0;
        else        lat_q <= lat_d;
    end

    assign lat_addr  = lat_q.addr;
    assign lat_bank  = lat_q.bank;
    assign lat_mode  = lat_q.mode;
    assign lat_split = lat_q.split;

    // Address and bank hold through the data phase
    assert_hold_addr_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !ale |=> $stable(lat_q.addr));
    assert_hold_bank_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !ale |=> $stable(lat_q.bank));

endmodule

// File: rtl/sbr_bank_map.sv
module sbr_bank_map
    import sbr_pkg::*;
#(
    parameter int unsigned     CPU_AW   = 16,
    parameter int unsigned     SRAM_AW  = 19,
    parameter int unsigned     BANK_W   = 4,
    parameter int unsigned     WBANK_W  = 3,
    parameter logic [CPU_AW-1:0] HOLE_END = 16'h2200
) (
    input  logic [CPU_AW-1:0]  cpu_addr,
    input  logic [BANK_W-1:0]  bank,
    input  logic               mode,
    input  logic               split,
    output logic [SRAM_AW-1:0] sram_addr,
    output logic [NCHIP-1:0]   chip_sel,
    output logic               hit
);

    localparam int unsigned WIN_SIZE = (1 << CPU_AW) - int'(HOLE_END);
    localparam int unsigned OFF_W    = SRAM_AW + WBANK_W + 1;
    localparam int unsigned PG_W     = CPU_AW - 1;
    localparam int unsigned SEL_W    = SRAM_AW - PG_W;
    localparam logic [OFF_W-1:0] SRAM_TOP = OFF_W'((1 << SRAM_AW) - 1);

    logic [OFF_W-1:0]   win_off;
    logic               win_ovf;
    logic [SRAM_AW-1:0] page_addr;
    logic               in_hole;
    logic               chip_idx;

    // Window style: windows laid end to end behind the on-chip hole
    always_comb begin
        win_off = OFF_W'(bank[WBANK_W-1:0]) * OFF_W'(WIN_SIZE)
                + OFF_W'(cpu_addr - HOLE_END);
        win_ovf = (win_off > SRAM_TOP);
    end

    // Page style: bank bits above the low fifteen CPU address bits
    generate
        if (BANK_W >= SEL_W) begin : g_page_full
            assign page_addr = {bank[SEL_W-1:0], cpu_addr[PG_W-1:0]};
        end else begin : g_page_pad
            assign page_addr = {{(SEL_W-BANK_W){1'b0}}, bank, cpu_addr[PG_W-1:0]};
        end
    endgenerate

    always_comb begin
        in_hole = (cpu_addr < HOLE_END);
        if (map_mode_e'(mode) == MAP_WINDOW) begin
            sram_addr = win_off[SRAM_AW-1:0];
            chip_idx  = bank[BANK_W-1];
            hit       = !in_hole && !win_ovf;
        end else begin
            sram_addr = page_addr;
            chip_idx  = split ? cpu_addr[CPU_AW-1] : 1'b0;
            hit       = !in_hole;
        end
    end

    generate
        for (genvar c = 0; c < NCHIP; c++) begin : g_chip
            assign chip_sel[c] = hit && (int'(chip_idx) == c);
        end
    endgenerate

    assert_one_chip_R4: assert final ($onehot0(chip_sel));

endmodule

// File: rtl/sbr_bus_ctrl.sv
module sbr_bus_ctrl
    import sbr_pkg::*;
#(
    parameter int unsigned DATA_W  = 8,
    parameter int unsigned SRAM_AW = 19
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ale,
    input  logic               rd_n,
    input  logic               wr_n,
    input  logic [DATA_W-1:0]  ad_in,
    input  logic [SRAM_AW-1:0] map_addr,
    input  logic [NCHIP-1:0]   map_sel,
    input  logic               map_hit,
    input  logic [DATA_W-1:0]  sram_d_in,
    output logic [SRAM_AW-1:0] sram_addr,
    output logic [NCHIP-1:0]   ce_n,
    output logic               oe_n,
    output logic               we_n,
    output logic [DATA_W-1:0]  ad_out,
    output logic               ad_oe,
    output logic [DATA_W-1:0]  d_out,
    output logic               d_oe
);

    typedef struct packed {
        logic [SRAM_AW-1:0] addr;
        logic [NCHIP-1:0]   ce_n;
        logic               oe_n;
        logic               we_n;
        logic [DATA_W-1:0]  ad_out;
        logic               ad_oe;
        logic [DATA_W-1:0]  d_out;
        logic               d_oe;
    } ctl_t;

    localparam ctl_t CTL_RST = '{
        addr: '0, ce_n: '1, oe_n: 1'b1, we_n: 1'b1,
        ad_out: '0, ad_oe: 1'b0, d_out: '0, d_oe: 1'b0
    };

    ctl_t ctl_d, ctl_q;
    logic rd_go, wr_go;

    always_comb begin
        rd_go = !ale && !rd_n && map_hit;
        wr_go = !ale && !wr_n && rd_n && map_hit;

        ctl_d        = ctl_q;
        ctl_d.addr   = map_addr;
        ctl_d.ce_n   = (rd_go || wr_go) ? ~map_sel : '1;
        ctl_d.oe_n   = !rd_go;
        ctl_d.we_n   = !wr_go;
        ctl_d.ad_oe  = rd_go;
        ctl_d.d_oe   = wr_go;
        if (rd_go) ctl_d.ad_out = sram_d_in;
        if (wr_go) ctl_d.d_out  = ad_in;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctl_q <= CTL_RST;
        else        ctl_q <= ctl_d;
    end

    assign sram_addr = ctl_q.addr;
    assign ce_n      = ctl_q.ce_n;
    assign oe_n      = ctl_q.oe_n;
    assign we_n      = ctl_q.we_n;
    assign ad_out    = ctl_q.ad_out;
    assign ad_oe     = ctl_q.ad_oe;
    assign d_out     = ctl_q.d_out;
    assign d_oe      = ctl_q.d_oe;

    assert_rd_wr_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(!ctl_q.oe_n && !ctl_q.we_n));
    assert_oe_drives_bus_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_q.oe_n |-> (ctl_q.ad_oe && !ctl_q.d_oe));
    assert_we_drives_sram_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_q.we_n |-> (ctl_q.d_oe && !ctl_q.ad_oe));
    assert_enable_needs_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rd_n) && $past(wr_n)) |-> (&ctl_q.ce_n));
    assert_single_chip_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(~ctl_q.ce_n) <= 1);

endmodule

// File: rtl/banked_sram_bridge.sv
module banked_sram_bridge
    import sbr_pkg::*;
#(
    parameter int unsigned       CPU_AW   = CPU_AW_DEF,
    parameter int unsigned       DATA_W   = DATA_W_DEF,
    parameter int unsigned       SRAM_AW  = SRAM_AW_DEF,
    parameter int unsigned       BANK_W   = BANK_W_DEF,
    parameter int unsigned       WBANK_W  = WBANK_W_DEF,
    parameter logic [CPU_AW-1:0] HOLE_END = 16'h2200
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     ale,
    input  logic                     rd_n,
    input  logic                     wr_n,
    input  logic [CPU_AW-DATA_W-1:0] addr_hi,
    input  logic [DATA_W-1:0]        ad_in,
    output logic [DATA_W-1:0]        ad_out,
    output logic                     ad_oe,
    input  logic [BANK_W-1:0]        bank_sel,
    input  logic                     cfg_mode,
    input  logic                     cfg_split,
    output logic [SRAM_AW-1:0]       sram_addr,
    output logic                     sram_ce0_n,
    output logic                     sram_ce1_n,
    output logic                     sram_oe_n,
    output logic                     sram_we_n,
    input  logic [DATA_W-1:0]        sram_d_in,
    output logic [DATA_W-1:0]        sram_d_out,
    output logic                     sram_d_oe
);

    logic [CPU_AW-1:0]  lat_addr;
    logic [BANK_W-1:0]  lat_bank;
    logic               lat_mode;
    logic               lat_split;
    logic [SRAM_AW-1:0] map_addr;
    logic [NCHIP-1:0]   map_sel;
    logic               map_hit;
    logic [NCHIP-1:0]   ce_n;

    sbr_addr_latch #(
        .CPU_AW (CPU_AW),
        .DATA_W (DATA_W),
        .BANK_W (BANK_W)
    ) i_latch (
        .clk       (clk),
        .rst_n     (rst_n),
        .ale       (ale),
        .addr_hi   (addr_hi),
        .ad_in     (ad_in),
        .bank_sel  (bank_sel),
        .cfg_mode  (cfg_mode),
        .cfg_split (cfg_split),
        .lat_addr  (lat_addr),
        .lat_bank  (lat_bank),
        .lat_mode  (lat_mode),
        .lat_split (lat_split)
    );

    sbr_bank_map #(
        .CPU_AW   (CPU_AW),
        .SRAM_AW  (SRAM_AW),
        .BANK_W   (BANK_W),
        .WBANK_W  (WBANK_W),
        .HOLE_END (HOLE_END)
    ) i_map (
        .cpu_addr  (lat_addr),
        .bank      (lat_bank),
        .mode      (lat_mode),
        .split     (lat_split),
        .sram_addr (map_addr),
        .chip_sel  (map_sel),
        .hit       (map_hit)
    );

    sbr_bus_ctrl #(
        .DATA_W  (DATA_W),
        .SRAM_AW (SRAM_AW)
    ) i_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .ale       (ale),
        .rd_n      (rd_n),
        .wr_n      (wr_n),
        .ad_in     (ad_in),
        .map_addr  (map_addr),
        .map_sel   (map_sel),
        .map_hit   (map_hit),
        .sram_d_in (sram_d_in),
        .sram_addr (sram_addr),
        .ce_n      (ce_n),
        .oe_n      (sram_oe_n),
        .we_n      (sram_we_n),
        .ad_out    (ad_out),
        .ad_oe     (ad_oe),
        .d_out     (sram_d_out),
        .d_oe      (sram_d_oe)
    );

    assign sram_ce0_n = ce_n[0];
    assign sram_ce1_n = ce_n[1];

    // No chip enable for an address served on-chip
    assert_hole_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!sram_ce0_n || !sram_ce1_n) |-> ($past(lat_addr) >= HOLE_END));
    // Second chip only when the captured configuration allows it
    assert_ce1_allowed_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !sram_ce1_n |-> ($past(lat_mode) == 1'b0 || $past(lat_split)));
    assert_split_a15_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!sram_ce1_n && $past(lat_mode)) |-> $past(lat_addr[CPU_AW-1]));

endmodule

// File: tb/test_banked_sram_bridge.sv
`timescale 1ns/1ps
module test_banked_sram_bridge;

    localparam real TCK = 8.0;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ale = 1'b0, rd_n = 1'b1, wr_n = 1'b1;
    logic [7:0]  addr_hi = '0, ad_in = '0;
    logic [3:0]  bank_sel = '0;
    logic        cfg_mode = 1'b0, cfg_split = 1'b0;
    logic [7:0]  ad_out, sram_d_out, sram_d_in;
    logic        ad_oe, sram_d_oe;
    logic [18:0] sram_addr;
    logic        sram_ce0_n, sram_ce1_n, sram_oe_n, sram_we_n;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #(TCK/2) clk = ~clk;

    banked_sram_bridge i_banked_sram_bridge (
        .clk(clk), .rst_n(rst_n), .ale(ale), .rd_n(rd_n), .wr_n(wr_n),
        .addr_hi(addr_hi), .ad_in(ad_in), .ad_out(ad_out), .ad_oe(ad_oe),
        .bank_sel(bank_sel), .cfg_mode(cfg_mode), .cfg_split(cfg_split),
        .sram_addr(sram_addr), .sram_ce0_n(sram_ce0_n), .sram_ce1_n(sram_ce1_n),
        .sram_oe_n(sram_oe_n), .sram_we_n(sram_we_n), .sram_d_in(sram_d_in),
        .sram_d_out(sram_d_out), .sram_d_oe(sram_d_oe)
    );

    function automatic logic [7:0] pattern(input logic [18:0] a, input logic chip);
        return a[7:0] ^ a[15:8] ^ {chip, 4'b0101, a[18:16]};
    endfunction

    // SRAM model: content is a fixed function of address and chip
    assign sram_d_in = pattern(sram_addr, !sram_ce1_n);

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // Independent model of the mapping
    task automatic model(input logic [15:0] cpu, input logic [3:0] bank,
                         input bit mode, input bit split,
                         output int addr, output bit chip, output bit hit);
        hit = (cpu >= 16'h2200);
        if (!mode) begin
            addr = int'(bank[2:0]) * 56832 + int'(cpu) - 'h2200;
            chip = bank[3];
            if (addr > 'h7FFFF) hit = 0;
        end else begin
            addr = int'({bank, cpu[14:0]});
            chip = split ? cpu[15] : 1'b0;
        end
    endtask

    // One bus cycle: address phase, two data-phase edges, then release
    task automatic access(input bit is_rd, input bit both, input logic [15:0] cpu,
                          input logic [3:0] bank, input bit mode, input bit split,
                          input logic [7:0] dat, input string tag);
        int ea; bit ec, eh;
        model(cpu, bank, mode, split, ea, ec, eh);
        @(negedge clk);
        ale = 1; addr_hi = cpu[15:8]; ad_in = cpu[7:0];
        bank_sel = bank; cfg_mode = mode; cfg_split = split;
        @(negedge clk);
        ale = 0; ad_in = dat;
        bank_sel = ~bank;                 // R9: mid-access change has no effect
        rd_n = !(is_rd || both); wr_n = !(!is_rd || both);
        @(negedge clk);
        @(negedge clk);
        chk(sram_addr == ea[18:0], {tag, " R3/R5 R1 R9 addr"}, sram_addr, ea);
        chk(sram_ce0_n == !(eh && !ec), {tag, " R2 R4 R6 ce0"}, sram_ce0_n, !(eh && !ec));
        chk(sram_ce1_n == !(eh && ec), {tag, " R2 R4 R6 ce1"}, sram_ce1_n, !(eh && ec));
        if (is_rd || both) begin
            chk(sram_oe_n == !eh && sram_we_n, {tag, " R7 oe"}, sram_oe_n, !eh);
            if (eh) begin
                chk(ad_out == pattern(ea[18:0], ec) && ad_oe, {tag, " R8 read data"},
                    ad_out, pattern(ea[18:0], ec));
            end
        end else begin
            chk(sram_we_n == !eh && sram_oe_n, {tag, " R7 we"}, sram_we_n, !eh);
            if (eh) chk(sram_d_out == dat && sram_d_oe, {tag, " R8 write data"}, sram_d_out, dat);
        end
        rd_n = 1; wr_n = 1;
        @(negedge clk);
        chk(sram_ce0_n && sram_ce1_n && sram_oe_n && sram_we_n && !ad_oe && !sram_d_oe,
            {tag, " R7 R10 idle"}, {sram_ce0_n, sram_ce1_n, sram_oe_n, sram_we_n}, 'hF);
    endtask

    initial begin
        #(TCK * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        repeat (3) @(negedge clk);
        // R11 reset state
        chk(sram_ce0_n && sram_ce1_n && sram_oe_n && sram_we_n, "R11 enables", 
            {sram_ce0_n, sram_ce1_n, sram_oe_n, sram_we_n}, 'hF);
        chk(!ad_oe && !sram_d_oe && sram_addr == 0, "R11 outputs", sram_addr, 0);
        rst_n = 1;

        access(1, 0, 16'h21FF, 4'h0, 0, 0, 8'h00, "hole top R2");
        access(0, 0, 16'h0000, 4'h5, 1, 1, 8'h3C, "hole base R2");
        access(1, 0, 16'h2200, 4'h0, 0, 0, 8'hAA, "window first R3");
        access(1, 0, 16'hFFFF, 4'h7, 0, 0, 8'h55, "window last R3");
        access(0, 0, 16'h8000, 4'hB, 0, 0, 8'hC3, "window chip1 R4");
        access(1, 0, 16'hA200, 4'h9, 1, 0, 8'h11, "page alias R5");
        access(1, 0, 16'h2200, 4'h9, 1, 0, 8'h22, "page base R5");
        access(1, 0, 16'hA200, 4'h9, 1, 1, 8'h33, "split hi R6");
        access(0, 0, 16'h7FFF, 4'hF, 1, 1, 8'h44, "split lo R6");
        access(1, 1, 16'h4321, 4'h2, 0, 0, 8'h66, "both strobes R7");
        access(0, 0, 16'h3456, 4'h1, 0, 0, 8'hE7, "write R8");

        for (int i = 0; i < 400; i++) begin
            logic [15:0] a = 16'($urandom);
            if (($urandom % 8) == 0) a = 16'h2200 + 16'($urandom % 4) - 16'd2;
            access(bit'($urandom % 2), bit'(($urandom % 16) == 0), a,
                   4'($urandom), bit'($urandom % 2), bit'($urandom % 2),
                   8'($urandom), "random R1 R9");
        end

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule